// File: doc/BRIEF.md
# Four-Channel Compare/Capture/PWM Array

The block holds one counter and four channels that read it. The counter either runs upward and wraps to zero after reaching a programmable top value, or runs up to the top value and back down to zero in a triangle. Each channel works either as a capture unit or as a compare unit. As a capture unit it stores the counter value when its pin shows a selected edge. As a compare unit it changes a waveform bit when the counter equals the channel's compare value.

Software reaches the channels through a small register port. A select register decides which channel's compare value and control byte are visible at the shared addresses. Each channel has a sticky event flag and an interrupt enable, and one interrupt line collects them. A compare value can be written into a shadow copy that moves into the active copy either on the next clock or only at the counter minimum. A phase-steering stage can let exactly one channel of a group drive its output at a time, and it moves to the next channel after each full counter period in either direction.

Top module: `ccp_array`

## Requirements
- R1: After reset the counter, all flags, all channel settings and all outputs are zero, and `irq` is low.
- R2: With run set (ctrl bit 0) and dual-slope clear (ctrl bit 1), the counter steps by one per clock and moves from any value at or above TOP (address 1) to zero. A write to address 6 loads the counter on the next clock.
- R3: With run and dual-slope set, the counter steps up to TOP, then steps down to zero, then up again, so one period lasts 2*TOP clocks.
- R4: Address 2 holds the channel select. Addresses 3 (shadow compare value), 4 (channel control) and 7 (active compare value) reach only the selected channel, for both reads and writes.
- R5: A channel whose control mode field (bits 1:0) equals 1 captures on its pin. Field bits 3:2 pick the edge: 1 falling, 2 rising, 3 both, 0 none. An edge of any other kind leaves the flag and the stored value unchanged.
- R6: A capture copies the counter into the channel's shadow and active values only while run is set. A selected edge with the counter stopped still sets the channel's flag.
- R7: A channel with mode 2 compares while run is set. When the counter equals the active value in single-slope counting, bits 3:2 act on the waveform: 1 sets it, 2 clears it, 3 toggles it. In dual-slope counting every match toggles it. The pin shows the waveform only while the mode is 2.
- R8: With run clear, the counter holds its value and no compare match occurs.
- R9: A capture or a compare match sets the channel's flag (address 5, bit n for channel n). The flag stays set until a write to address 5 with bit n set, and in the same clock a new event takes priority over the clear.
- R10: `irq` is high exactly when some channel has both its flag and its interrupt enable (control bit 4) set.
- R11: With the buffered bit (ctrl bit 2) clear, the active compare value takes the shadow value one clock later. With it set, the transfer happens only in a clock where run is set and the counter is zero.
- R12: The phase field (ctrl bits 4:3) equal to p > 0 forms a group of channels 0 to p, and only one of them drives its pin. After each completed period the driving channel moves up by one (direction bit, ctrl bit 5, clear) or down by one (set), wrapping within the group. With p = 0 no steering applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data, combinational |
| cap_in | input | NCH | Capture pins, one per channel |
| ccp_out | output | NCH | Compare waveform pins after phase steering |
| irq | output | 1 | Combined channel interrupt |

## Verification
On every cycle the assertions check the counter's single-step progress in both directions, that it holds while stopped, that flags never drop without a clear, that a buffered compare value stays put outside the counter minimum, that a set action raises the waveform, and that steering lets at most one pin drive. The choice of edge, the captured value, the toggle-per-crossing pattern in dual slope, the order and direction of the rotating channel and the channel-select indirection can only be shown by the bench's scenarios, where a behavioural model predicts every output and read value each clock.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_CAP = 2'd1,
        MODE_CMP = 2'd2,
        MODE_RSV = 2'd3
    } ch_mode_e;

    // Channel control: interrupt enable, edge/action select, mode.
    typedef struct packed {
        logic       ie;
        logic [1:0] act;
        ch_mode_e   mode;
    } chctl_t;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_TOP   = 3'd1;
    localparam logic [2:0] A_SEL   = 3'd2;
    localparam logic [2:0] A_CMP   = 3'd3;
    localparam logic [2:0] A_CHCTL = 3'd4;
    localparam logic [2:0] A_FLAGS = 3'd5;
    localparam logic [2:0] A_COUNT = 3'd6;
    localparam logic [2:0] A_ACT   = 3'd7;

endpackage

// File: rtl/ccp_timebase.sv
module ccp_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         dual,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         at_min,
    output logic         period_end
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } tb_t;

    tb_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        period_end = 1'b0;
        if (run) begin
            if (!dual) begin
                s_d.down = 1'b0;
                if (s_q.cnt >= top) begin
                    s_d.cnt    = '0;
                    period_end = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else if (!s_q.down) begin
                if (s_q.cnt >= top) begin
                    s_d.down = 1'b1;
                    s_d.cnt  = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.down   = 1'b0;
                    period_end = 1'b1;
                    s_d.cnt    = (top == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end
        if (load) begin
            s_d.cnt  = load_val;
            s_d.down = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt    = s_q.cnt;
    assign at_min = run && (s_q.cnt == '0);

    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !dual && !load && s_q.cnt < top) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dual && !load && s_q.down && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(s_q.cnt));

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         dual,
    input  logic         pfc,
    input  logic         at_min,
    input  logic [W-1:0] cnt,
    input  chctl_t       cfg,
    input  logic         shd_we,
    input  logic [W-1:0] shd_wdata,
    input  logic         flag_clr,
    input  logic         cap_pin,
    output logic         wave,
    output logic         flag,
    output logic [W-1:0] shd_val,
    output logic [W-1:0] act_val
);

    typedef struct packed {
        logic         wave;
        logic         flag;
        logic         prev;
        logic [W-1:0] shd;
        logic [W-1:0] act;
    } ch_t;

    ch_t  s_d, s_q;
    logic rise, fall, edge_ok, cap_evt, match;

    always_comb begin
        rise = cap_pin & ~s_q.prev;
        fall = ~cap_pin & s_q.prev;
        unique case (cfg.act)
            2'd1:    edge_ok = fall;
            2'd2:    edge_ok = rise;
            2'd3:    edge_ok = rise | fall;
            default: edge_ok = 1'b0;
        endcase
        cap_evt = (cfg.mode == MODE_CAP) && edge_ok;
        match   = run && (cfg.mode == MODE_CMP) && (cnt == s_q.act);

        s_d      = s_q;
        s_d.prev = cap_pin;

        if (match) begin
            if (dual) begin
                s_d.wave = ~s_q.wave;
            end else begin
                unique case (cfg.act)
                    2'd1:    s_d.wave = 1'b1;
                    2'd2:    s_d.wave = 1'b0;
                    2'd3:    s_d.wave = ~s_q.wave;
                    default: s_d.wave = s_q.wave;
                endcase
            end
        end

        if (shd_we) s_d.shd = shd_wdata;

        if (cap_evt && run) begin
            s_d.shd = cnt;
            s_d.act = cnt;
        end else if (!pfc || at_min) begin
            s_d.act = s_q.shd;
        end

        s_d.flag = (s_q.flag & ~flag_clr) | cap_evt | match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wave    = s_q.wave;
    assign flag    = s_q.flag;
    assign shd_val = s_q.shd;
    assign act_val = s_q.act;

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !flag_clr) |=> s_q.flag);

    p_pfc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pfc && !at_min && !(cap_evt && run)) |=> $stable(s_q.act));

    p_stopped_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !shd_we) |=> $stable(s_q.shd));

    p_cmp_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !dual && cfg.act == 2'd1) |=> s_q.wave);

endmodule

// File: rtl/ccp_steer.sv
module ccp_steer #(
    parameter int NCH   = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ph,
    input  logic             dir,
    input  logic             period_end,
    output logic [NCH-1:0]   en
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ph == '0) begin
            s_d.idx = '0;
        end else if (period_end) begin
            if (!dir) begin
                s_d.idx = (s_q.idx >= ph) ? '0 : s_q.idx + 1'b1;
            end else begin
                s_d.idx = (s_q.idx == '0 || s_q.idx > ph) ? ph : s_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_en
        assign en[g] = (ph == '0) || (s_q.idx == IDX_W'(g));
    end

    p_single_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0) |-> ($countones(en) == 1));

endmodule

// File: rtl/ccp_array.sv
module ccp_array
    import ccp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [NCH-1:0]   cap_in,
    output logic [NCH-1:0]   ccp_out,
    output logic             irq
);

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic                  run;
        logic                  dual;
        logic                  pfc;
        logic [IDX_W-1:0]      ph;
        logic                  dir;
        logic [CNT_W-1:0]      top;
        logic [IDX_W-1:0]      sel;
        chctl_t [NCH-1:0]      cfg;
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0] cnt;
    logic             at_min, period_end, load;
    logic [NCH-1:0]   wave_v, flag_v, cmp_v, ie_v, en_v, shd_we_v, clr_v;
    logic [CNT_W-1:0] shd_a [NCH];
    logic [CNT_W-1:0] act_a [NCH];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    r_d.run  = wr_data[0];
                    r_d.dual = wr_data[1];
                    r_d.pfc  = wr_data[2];
                    r_d.ph   = wr_data[3 +: IDX_W];
                    r_d.dir  = wr_data[3 + IDX_W];
                end
                A_TOP:   r_d.top = wr_data;
                A_SEL:   r_d.sel = wr_data[IDX_W-1:0];
                A_CHCTL: r_d.cfg[r_q.sel] = chctl_t'(wr_data[4:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign load = wr_en && (wr_addr == A_COUNT);

    ccp_timebase #(.W(CNT_W)) i_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (r_q.run),
        .dual       (r_q.dual),
        .load       (load),
        .load_val   (wr_data),
        .top        (r_q.top),
        .cnt        (cnt),
        .at_min     (at_min),
        .period_end (period_end)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign shd_we_v[g] = wr_en && (wr_addr == A_CMP) && (r_q.sel == IDX_W'(g));
        assign clr_v[g]    = wr_en && (wr_addr == A_FLAGS) && wr_data[g];
        assign cmp_v[g]    = (r_q.cfg[g].mode == MODE_CMP);
        assign ie_v[g]     = r_q.cfg[g].ie;

        ccp_channel #(.W(CNT_W)) i_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (r_q.run),
            .dual      (r_q.dual),
            .pfc       (r_q.pfc),
            .at_min    (at_min),
            .cnt       (cnt),
            .cfg       (r_q.cfg[g]),
            .shd_we    (shd_we_v[g]),
            .shd_wdata (wr_data),
            .flag_clr  (clr_v[g]),
            .cap_pin   (cap_in[g]),
            .wave      (wave_v[g]),
            .flag      (flag_v[g]),
            .shd_val   (shd_a[g]),
            .act_val   (act_a[g])
        );
    end

    ccp_steer #(.NCH(NCH), .IDX_W(IDX_W)) i_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (r_q.ph),
        .dir        (r_q.dir),
        .period_end (period_end),
        .en         (en_v)
    );

    assign ccp_out = wave_v & cmp_v & en_v;
    assign irq     = |(flag_v & ie_v);

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = CNT_W'({r_q.dir, r_q.ph, r_q.pfc, r_q.dual, r_q.run});
            A_TOP:   rd_data = r_q.top;
            A_SEL:   rd_data = CNT_W'(r_q.sel);
            A_CMP:   rd_data = shd_a[r_q.sel];
            A_CHCTL: rd_data = CNT_W'(r_q.cfg[r_q.sel]);
            A_FLAGS: rd_data = CNT_W'(flag_v);
            A_COUNT: rd_data = cnt;
            default: rd_data = act_a[r_q.sel];
        endcase
    end

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_v == '0) |-> !irq);

    p_steer_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph != '0) |-> ($countones(ccp_out) <= 1));

endmodule

// File: tb/test_ccp_array.sv
module test_ccp_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  cap_in = '0;
    logic [3:0]  ccp_out;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit rot_en = 1'b1;

    always #5 clk = ~clk;

    ccp_array i_ccp_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .ccp_out(ccp_out), .irq(irq)
    );

    // Behavioural reference model.
    int m_run, m_dual, m_pfc, m_ph, m_dir, m_top, m_sel, m_cnt, m_down, m_idx;
    int m_shd[4], m_act[4], m_mode[4], m_ea[4], m_ie[4], m_flag[4], m_wave[4], m_prev[4];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_dual = 0; m_pfc = 0; m_ph = 0; m_dir = 0; m_top = 0;
            m_sel = 0; m_cnt = 0; m_down = 0; m_idx = 0;
            for (int i = 0; i < 4; i++) begin
                m_shd[i] = 0; m_act[i] = 0; m_mode[i] = 0; m_ea[i] = 0;
                m_ie[i] = 0; m_flag[i] = 0; m_wave[i] = 0; m_prev[i] = 0;
            end
        end else begin
            int ncnt, ndown, pend, wd;
            int cev[4], hit[4];
            wd = int'(wr_data);
            pend = 0; ncnt = m_cnt; ndown = m_down;
            for (int i = 0; i < 4; i++) begin
                int r, f;
                r = (cap_in[i] && !m_prev[i]) ? 1 : 0;
                f = (!cap_in[i] && m_prev[i]) ? 1 : 0;
                cev[i] = (m_mode[i] == 1) &&
                         ((m_ea[i] == 1 && f) || (m_ea[i] == 2 && r) || (m_ea[i] == 3 && (r || f)));
                hit[i] = m_run && m_mode[i] == 2 && m_cnt == m_act[i];
            end
            if (m_run) begin
                if (!m_dual) begin
                    ndown = 0;
                    if (m_cnt >= m_top) begin ncnt = 0; pend = 1; end
                    else ncnt = m_cnt + 1;
                end else if (!m_down) begin
                    if (m_cnt >= m_top) begin ndown = 1; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else ncnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin ndown = 0; pend = 1; ncnt = (m_top == 0) ? 0 : 1; end
                    else ncnt = m_cnt - 1;
                end
            end
            if (wr_en && wr_addr == 6) begin ncnt = wd; ndown = 0; end
            for (int i = 0; i < 4; i++) begin
                int old_shd;
                old_shd = m_shd[i];
                if (hit[i]) begin
                    if (m_dual) m_wave[i] = 1 - m_wave[i];
                    else if (m_ea[i] == 1) m_wave[i] = 1;
                    else if (m_ea[i] == 2) m_wave[i] = 0;
                    else if (m_ea[i] == 3) m_wave[i] = 1 - m_wave[i];
                end
                if (wr_en && wr_addr == 3 && m_sel == i) m_shd[i] = wd;
                if (cev[i] && m_run) begin m_shd[i] = m_cnt; m_act[i] = m_cnt; end
                else if (!m_pfc || (m_run && m_cnt == 0)) m_act[i] = old_shd;
                if (wr_en && wr_addr == 5 && wd[i]) m_flag[i] = 0;
                if (cev[i] || hit[i]) m_flag[i] = 1;
                m_prev[i] = cap_in[i] ? 1 : 0;
            end
            if (m_ph == 0) m_idx = 0;
            else if (pend) begin
                if (!m_dir) m_idx = (m_idx >= m_ph) ? 0 : m_idx + 1;
                else m_idx = (m_idx == 0 || m_idx > m_ph) ? m_ph : m_idx - 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    0: begin m_run = wd & 1; m_dual = (wd >> 1) & 1; m_pfc = (wd >> 2) & 1;
                             m_ph = (wd >> 3) & 3; m_dir = (wd >> 5) & 1; end
                    1: m_top = wd;
                    2: m_sel = wd & 3;
                    4: begin m_mode[m_sel] = wd & 3; m_ea[m_sel] = (wd >> 2) & 3;
                             m_ie[m_sel] = (wd >> 4) & 1; end
                    default: ;
                endcase
            end
            m_cnt = ncnt; m_down = ndown;
        end
    end

    function automatic int m_out();
        int o = 0;
        for (int i = 0; i < 4; i++)
            if (m_wave[i] && m_mode[i] == 2 && (m_ph == 0 || m_idx == i)) o |= (1 << i);
        return o;
    endfunction

    function automatic int m_irq();
        int o = 0;
        for (int i = 0; i < 4; i++) if (m_flag[i] && m_ie[i]) o = 1;
        return o;
    endfunction

    function automatic int m_flags();
        int o = 0;
        for (int i = 0; i < 4; i++) if (m_flag[i]) o |= (1 << i);
        return o;
    endfunction

    function automatic int m_rd(int a);
        case (a)
            0: return m_run | (m_dual << 1) | (m_pfc << 2) | (m_ph << 3) | (m_dir << 5);
            1: return m_top;
            2: return m_sel;
            3: return m_shd[m_sel];
            4: return m_mode[m_sel] | (m_ea[m_sel] << 2) | (m_ie[m_sel] << 4);
            5: return m_flags();
            6: return m_cnt;
            default: return m_act[m_sel];
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Rotating read address and per-clock comparison against the model.
    always @(negedge clk) begin
        cyc++;
        if (rot_en) rd_addr = 3'(cyc);
        #1;
        if (rst_n) begin
            chk("R7 R12 pin outputs", int'(ccp_out), m_out());
            chk("R10 irq", int'(irq), m_irq());
            chk("R4 read port", int'(rd_data), m_rd(int'(rd_addr)));
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
            summary();
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        rot_en = 1'b0;
        @(negedge clk);
        rd_addr = 3'(a);
        #2;
        v = int'(rd_data);
        rot_en = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin(int ch, bit v);
        @(negedge clk);
        cap_in[ch] = v;
    endtask

    initial begin
        int v, v2;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(6, v); chk("R1 count after reset", v, 0);
        rd(5, v); chk("R1 flags after reset", v, 0);
        chk("R1 outputs after reset", int'(ccp_out), 0);
        chk("R1 irq after reset", int'(irq), 0);

        // Single slope, three compare actions.
        wr(1, 9);
        wr(2, 0); wr(4, 16'h16); wr(3, 3);
        rd(7, v); chk("R11 unbuffered transfer", v, 3);
        rd(4, v); chk("R4 selected control", v, 16'h16);
        wr(2, 1); wr(4, 16'h0A); wr(3, 6);
        rd(3, v); chk("R4 selected shadow", v, 6);
        wr(2, 0);
        rd(3, v); chk("R4 other channel kept", v, 3);
        wr(2, 2); wr(4, 16'h0E); wr(3, 8);
        wr(0, 1);
        idle(3);
        rd(6, v); rd(6, v2); chk("R2 step by one", (v2 - v + 10) % 10, 1);
        idle(40);
        wr(0, 0);
        rd(5, v); chk("R9 flags set by matches", v & 7, 7);
        chk("R10 irq from enabled channel", int'(irq), 1);
        wr(5, 1);
        rd(5, v); chk("R9 write-one clears bit", v & 7, 6);
        chk("R10 irq low with only disabled flags", int'(irq), 0);
        rd(6, v); idle(5); rd(6, v2); chk("R8 counter holds when stopped", v2, v);
        rd(5, v); chk("R8 no match when stopped", v & 1, 0);

        // Capture on channel D.
        wr(2, 3); wr(4, 16'h19);
        rd(7, v);
        pin(3, 1'b1); idle(2);
        rd(5, v2); chk("R6 stopped edge sets flag", (v2 >> 3) & 1, 1);
        rd(7, v2); chk("R6 stopped edge stores nothing", v2, v);
        wr(5, 8);
        wr(0, 1); idle(4);
        pin(3, 1'b0); idle(2);
        rd(5, v); chk("R5 falling edge ignored when rising selected", (v >> 3) & 1, 0);
        idle(3);
        pin(3, 1'b1); idle(2);
        rd(5, v); chk("R5 rising edge sets flag", (v >> 3) & 1, 1);
        rd(7, v); chk("R6 value captured while running", v, m_act[3]);
        wr(4, 16'h1D); idle(2);
        pin(3, 1'b0); idle(3);
        rd(7, v); chk("R5 both-edge capture", v, m_act[3]);
        idle(5);

        // Dual slope with buffered compare.
        wr(0, 0); wr(6, 0); wr(1, 6);
        wr(2, 2); wr(4, 16'h0E); wr(3, 2);
        wr(0, 16'h07);
        idle(5);
        wr(3, 4);
        rd(7, v); chk("R11 buffered value waits for minimum", v, m_act[2]);
        idle(30);
        rd(6, v); chk("R3 dual slope count", v, m_cnt);
        rd(7, v); chk("R11 buffered value moved at minimum", v, 4);
        idle(20);

        // Phase steering across four channels, then two.
        wr(0, 0); wr(6, 0); wr(1, 3);
        for (int c = 0; c < 4; c++) begin
            wr(2, c); wr(4, 16'h0E); wr(3, 1);
        end
        wr(0, 16'h19);
        idle(40);
        chk("R12 only active channel drives", int'(ccp_out) & ~(1 << m_idx), 0);
        wr(0, 16'h39);
        idle(40);
        chk("R12 reverse rotation index in group", (m_idx <= 3) ? 1 : 0, 1);
        wr(0, 16'h09);
        idle(40);
        chk("R12 two-channel group", int'(ccp_out) & 4'b1100, 0);
        idle(5);
        summary();
    end

endmodule